// File: doc/BRIEF.md
# Parallel Port with Edge-Flag Control Input

This block is an 8-bit bidirectional parallel port with one control input that is sensitive only to edges. A processor reaches it through a small register file using a 4-bit offset, a chip select, and separate read and write strobes. Each port pin is either driven from an output register or read as an input. Direction is chosen per bit.

The control input passes through a synchroniser before edge detection. It is never visible as a level. When an edge of the programmed polarity arrives, a sticky flag is set. That edge can also freeze the port pins into an input latch. The flag can be polled with interrupts masked, or it can pull an active-low interrupt line low when enabled. Two access paths lead to the port data. A read or write at offset 0x1 clears the flag as a side effect. A read or write at offset 0xF reaches the same data without touching the flag. Software that polls the flag bit by bit therefore uses 0xF, so that it cannot clear a flag that is being set at that moment.

Top module: `pio_edge_port`

## Requirements
- R1: After reset, the output, direction, control and flag registers hold 0 and the interrupt is disabled. `padOe` is 0 and `irqN` is 1. A read of offset 0xE returns 0x80.
- R2: Offset 0x3 is the direction register. `padOe` equals its value, so a bit set to 1 makes that pin an output. `padOut` always shows the output register.
- R3: Writes at offset 0x1 and at offset 0xF both load the output register. A read at either offset returns, bit by bit, the output register where the direction bit is 1 and the input value where it is 0.
- R4: Bit 0 of the control register at offset 0xC selects the active edge of `ctlIn`: 0 selects falling and 1 selects rising. An edge of the other polarity leaves the flag unchanged. A read of 0xC returns {6'b0, latch enable, polarity}, independent of the `ctlIn` level.
- R5: An active edge sets bit 1 of the flag register at offset 0xD whatever the enable bit holds. With the enable bit at 0, the flag reads back as 0x02 and `irqN` stays 1.
- R6: Bit 1 of the control register enables input latching. With it set, an active edge captures `padIn`, and reads of input-direction bits at 0x1 or 0xF return the captured value. With it clear, they return the live pins.
- R7: A read or a write at offset 0x1 clears the flag. A read or a write at offset 0xF leaves the flag unchanged.
- R8: If an active edge is detected in the same cycle as a clearing access, the flag ends up set.
- R9: Bit 7 of a flag-register read is 1 exactly when the flag and its enable bit are both 1. `irqN` is 0 under that condition.
- R10: Writing 0xD with bit 1 set clears the flag. Writing 0xD with bit 1 clear leaves it unchanged.
- R11: A write to offset 0xE with data bit 1 set loads the enable bit with data bit 7; otherwise the enable bit is unchanged. A read of 0xE returns {1, 5'b0, enable, 0}.
- R12: Reads of offsets other than 0x1, 0x3, 0xC, 0xD, 0xE and 0xF return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe; side effects happen at the clock edge |
| wr | input | 1 | Write strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational; 0 when not reading) |
| padIn | input | 8 | Port pin input values |
| padOut | output | 8 | Port pin output values |
| padOe | output | 8 | Per-pin output enable |
| ctlIn | input | 1 | Edge-sensitive control input, asynchronous |
| irqN | output | 1 | Active-low interrupt request |

## Verification
Random mixes of direction masks, output values and pin values are applied through both data offsets. Each read is compared per bit against a merge model, which separates the output path from the input path and shows that the two data offsets behave alike. Directed control-input sequences apply edges of each polarity under both polarity settings, and show that only the programmed edge raises the flag. Clearing accesses are then placed at 0x1, at 0xF and at the flag register, which separates the clearing offset from the alternate offset. A clearing read timed into the exact cycle of edge detection shows that edge priority holds. A latched capture followed by a change on the pins separates the latched value from the live one.

// File: rtl/pio_edge_pkg.sv
package pio_edge_pkg;
  localparam int BusW = 8;
  localparam int AddrW = 4;

  localparam logic [AddrW-1:0] OffData = 4'h1;
  localparam logic [AddrW-1:0] OffDir = 4'h3;
  localparam logic [AddrW-1:0] OffCtrl = 4'hC;
  localparam logic [AddrW-1:0] OffFlag = 4'hD;
  localparam logic [AddrW-1:0] OffEnable = 4'hE;
  localparam logic [AddrW-1:0] OffAlt = 4'hF;

  localparam int FlagBit = 1;
  localparam int AnyBit = 7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_CTRL,
    SEL_FLAG,
    SEL_ENABLE
  } readSel_e;

  typedef struct packed {
    logic wrOut;
    logic wrDir;
    logic wrCtrl;
    logic wrFlag;
    logic wrEnable;
    logic clrFlag;
    readSel_e rdSel;
  } portStrobe_t;
endpackage

// File: rtl/pio_edge_sync.sv
module pio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : gSingle
      logic stageQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= 1'b0;
        else stageQ <= d;
      end
      assign q = stageQ;
    end else begin : gChain
      logic [STAGES-1:0] chainQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= '0;
        else chainQ <= {chainQ[STAGES-2:0], d};
      end
      assign q = chainQ[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pio_edge_ctrl.sv
module pio_edge_ctrl
  import pio_edge_pkg::*;
(
  input  logic cs,
  input  logic rd,
  input  logic wr,
  input  logic [AddrW-1:0] addr,
  output portStrobe_t stb
);
  always_comb begin
    stb = '0;
    stb.rdSel = SEL_NONE;
    if (cs && wr) begin
      unique case (addr)
        OffData: begin
          stb.wrOut = 1'b1;
          stb.clrFlag = 1'b1;
        end
        OffAlt: stb.wrOut = 1'b1;
        OffDir: stb.wrDir = 1'b1;
        OffCtrl: stb.wrCtrl = 1'b1;
        OffFlag: stb.wrFlag = 1'b1;
        OffEnable: stb.wrEnable = 1'b1;
        default: ;
      endcase
    end
    if (cs && rd) begin
      unique case (addr)
        OffData: begin
          stb.rdSel = SEL_DATA;
          stb.clrFlag = 1'b1;
        end
        OffAlt: stb.rdSel = SEL_DATA;
        OffDir: stb.rdSel = SEL_DIR;
        OffCtrl: stb.rdSel = SEL_CTRL;
        OffFlag: stb.rdSel = SEL_FLAG;
        OffEnable: stb.rdSel = SEL_ENABLE;
        default: stb.rdSel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pio_edge_dp.sv
module pio_edge_dp
  import pio_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  portStrobe_t stb,
  input  logic [BusW-1:0] wdata,
  output logic [BusW-1:0] rdata,
  input  logic [BusW-1:0] padIn,
  output logic [BusW-1:0] padOut,
  output logic [BusW-1:0] padOe,
  input  logic ctlIn,
  output logic irqN
);
  logic [BusW-1:0] outReg, dirReg, latchReg, portView;
  logic polRise, latchEn, enQ, flagQ;
  logic ctlSync, ctlPrev, edgeHit, anyIrq;

  pio_edge_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .d(ctlIn), .q(ctlSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctlPrev <= 1'b0;
    else ctlPrev <= ctlSync;
  end

  assign edgeHit = polRise ? (ctlSync & ~ctlPrev) : (~ctlSync & ctlPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      dirReg <= '0;
      polRise <= 1'b0;
      latchEn <= 1'b0;
      enQ <= 1'b0;
      latchReg <= '0;
    end else begin
      if (stb.wrOut) outReg <= wdata;
      if (stb.wrDir) dirReg <= wdata;
      if (stb.wrCtrl) begin
        polRise <= wdata[0];
        latchEn <= wdata[1];
      end
      if (stb.wrEnable && wdata[FlagBit]) enQ <= wdata[AnyBit];
      if (edgeHit && latchEn) latchReg <= padIn;
    end
  end

  // edge detection wins over any clearing access in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= 1'b0;
    else if (edgeHit) flagQ <= 1'b1;
    else if (stb.clrFlag || (stb.wrFlag && wdata[FlagBit])) flagQ <= 1'b0;
  end

  assign anyIrq = flagQ & enQ;
  assign irqN = ~anyIrq;
  assign padOut = outReg;
  assign padOe = dirReg;
  assign portView = (dirReg & outReg) | (~dirReg & (latchEn ? latchReg : padIn));

  always_comb begin
    rdata = '0;
    unique case (stb.rdSel)
      SEL_DATA: rdata = portView;
      SEL_DIR: rdata = dirReg;
      SEL_CTRL: rdata = {6'b0, latchEn, polRise};
      SEL_FLAG: begin
        rdata[AnyBit] = anyIrq;
        rdata[FlagBit] = flagQ;
      end
      SEL_ENABLE: begin
        rdata[AnyBit] = 1'b1;
        rdata[FlagBit] = enQ;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pio_edge_port.sv
module pio_edge_port
  import pio_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cs,
  input  logic rd,
  input  logic wr,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] padIn,
  output logic [7:0] padOut,
  output logic [7:0] padOe,
  input  logic ctlIn,
  output logic irqN
);
  portStrobe_t stb;

  pio_edge_ctrl uCtrl (
    .cs(cs), .rd(rd), .wr(wr), .addr(addr), .stb(stb)
  );

  pio_edge_dp #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(wdata), .rdata(rdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .ctlIn(ctlIn), .irqN(irqN)
  );
endmodule

// File: rtl/pio_edge_port_chk.sv
module pio_edge_port_chk (
  input logic clk,
  input logic rstN,
  input logic cs,
  input logic rd,
  input logic wr,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] padOe,
  input logic irqN,
  input logic flagQ,
  input logic edgeHit
);
  logic dataHit, flagWrClr;
  assign dataHit = cs && (rd || wr) && (addr == 4'h1);
  assign flagWrClr = cs && wr && (addr == 4'hD) && wdata[1];

  assert_dir_oe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wr && addr == 4'h3) |=> (padOe == $past(wdata)));

  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    edgeHit |=> flagQ);

  assert_data_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataHit && !edgeHit) |=> !flagQ);

  assert_alt_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cs && (rd || wr) && addr == 4'hF && flagQ) |=> flagQ);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !dataHit && !flagWrClr) |=> flagQ);

  assert_irq_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cs && rd && addr == 4'hD) |-> (rdata[7] == !irqN));

  assert_unmapped_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cs && rd && (addr == 4'h0 || addr == 4'h2 || (addr > 4'h3 && addr < 4'hC)))
      |-> (rdata == 8'h00));
endmodule

bind pio_edge_port pio_edge_port_chk uChk (
  .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
  .wdata(wdata), .rdata(rdata), .padOe(padOe), .irqN(irqN),
  .flagQ(uDp.flagQ), .edgeHit(uDp.edgeHit)
);

// File: tb/pio_edge_port_test.sv
`timescale 1ns/1ps
module pio_edge_port_test;
  logic clk = 0, rstN = 0, cs = 0, rd = 0, wr = 0, ctlIn = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, padIn = '0;
  logic [7:0] rdata, padOut, padOe;
  logic irqN;
  int checks = 0, errors = 0;
  logic [7:0] got;

  always #5 clk = ~clk;

  pio_edge_port uut (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .ctlIn(ctlIn), .irqN(irqN)
  );

  function automatic logic [7:0] portModel(logic [7:0] dir, logic [7:0] o, logic [7:0] pins);
    return (dir & o) | (~dir & pins);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic driveCtl(input logic v);
    @(negedge clk);
    ctlIn = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] mOut, mDir, mPins;
    void'($urandom(32'd2019));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 padOe", padOe, 8'h00);
    check("R1 irqN", {7'b0, irqN}, 8'h01);
    busRead(4'hD, got); check("R1 flag", got, 8'h00);
    busRead(4'hE, got); check("R1 enable", got, 8'h80);
    busRead(4'hC, got); check("R1 ctrl", got, 8'h00);
    busRead(4'h3, got); check("R1 dir", got, 8'h00);

    // R2 R3 directed merge
    padIn = 8'h3C;
    busWrite(4'h3, 8'hF0);
    busWrite(4'h1, 8'hA5);
    check("R2 padOe", padOe, 8'hF0);
    check("R2 padOut", padOut, 8'hA5);
    busRead(4'h1, got); check("R3 read data", got, 8'hAC);
    busWrite(4'hF, 8'h5A);
    check("R3 alt write", padOut, 8'h5A);
    busRead(4'hF, got); check("R3 alt read", got, 8'h5C);

    // R3 random patterns
    mOut = 8'h5A; mDir = 8'hF0; mPins = 8'h3C;
    for (int i = 0; i < 150; i++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: begin mOut = 8'($urandom); busWrite(4'h1, mOut); end
        1: begin mOut = 8'($urandom); busWrite(4'hF, mOut); end
        2: begin mDir = 8'($urandom); busWrite(4'h3, mDir); end
        default: begin @(negedge clk); mPins = 8'($urandom); padIn = mPins; end
      endcase
      busRead((i % 2) ? 4'h1 : 4'hF, got);
      check("R3 random read", got, portModel(mDir, mOut, mPins));
      check("R2 random oe", padOe, mDir);
      check("R2 random out", padOut, mOut);
    end

    // R4 falling polarity, R5 polled flag
    busWrite(4'h3, 8'h00);
    driveCtl(1);
    busRead(4'hD, got); check("R4 rise ignored when falling", got, 8'h00);
    busRead(4'hC, got); check("R4 ctrl no level", got, 8'h00);
    driveCtl(0);
    busRead(4'hD, got); check("R5 falling sets flag", got, 8'h02);
    check("R5 irqN masked", {7'b0, irqN}, 8'h01);
    // R10
    busWrite(4'hD, 8'hFD);
    busRead(4'hD, got); check("R10 write 0 keeps", got, 8'h02);
    busWrite(4'hD, 8'h02);
    busRead(4'hD, got); check("R10 write 1 clears", got, 8'h00);

    // R4 rising polarity
    busWrite(4'hC, 8'h01);
    driveCtl(1);
    busRead(4'hD, got); check("R4 rising sets", got, 8'h02);
    busWrite(4'hD, 8'h02);
    driveCtl(0);
    busRead(4'hD, got); check("R4 fall ignored when rising", got, 8'h00);

    // R7 clearing offsets
    driveCtl(1);
    busRead(4'hF, got);
    busRead(4'hD, got); check("R7 alt read keeps", got, 8'h02);
    busWrite(4'hF, 8'h77);
    busRead(4'hD, got); check("R7 alt write keeps", got, 8'h02);
    busRead(4'h1, got);
    busRead(4'hD, got); check("R7 data read clears", got, 8'h00);
    driveCtl(0);
    driveCtl(1);
    busWrite(4'h1, 8'h11);
    busRead(4'hD, got); check("R7 data write clears", got, 8'h00);

    // R9 R11 enable and interrupt
    driveCtl(0);
    driveCtl(1);
    busWrite(4'hE, 8'h82);
    busRead(4'hE, got); check("R11 enable set", got, 8'h82);
    check("R9 irqN asserted", {7'b0, irqN}, 8'h00);
    busRead(4'hD, got); check("R9 any bit", got, 8'h82);
    busWrite(4'hE, 8'h80);
    busRead(4'hE, got); check("R11 bit1 zero ignored", got, 8'h82);
    busWrite(4'hE, 8'h02);
    busRead(4'hE, got); check("R11 enable cleared", got, 8'h80);
    check("R9 irqN released", {7'b0, irqN}, 8'h01);
    busRead(4'hD, got); check("R9 any bit low", got, 8'h02);
    busWrite(4'hD, 8'h02);

    // R6 latching (ctlIn currently 1)
    driveCtl(0);
    busWrite(4'hC, 8'h03);
    busWrite(4'h3, 8'h00);
    @(negedge clk); padIn = 8'h5E;
    driveCtl(1);
    @(negedge clk); padIn = 8'h11;
    busRead(4'h1, got); check("R6 latched value", got, 8'h5E);
    busRead(4'hC, got); check("R6 ctrl readback", got, 8'h03);
    busWrite(4'hC, 8'h01);
    busRead(4'h1, got); check("R6 live when disabled", got, 8'h11);

    // R8 edge in the same cycle as a clearing read
    driveCtl(0);
    busWrite(4'hD, 8'h02);
    @(negedge clk); ctlIn = 1;
    @(negedge clk);
    @(negedge clk); cs = 1; rd = 1; addr = 4'h1;
    @(negedge clk); cs = 0; rd = 0;
    busRead(4'hD, got); check("R8 edge beats clear", got, 8'h02);

    // R12 unmapped offsets
    busRead(4'h0, got); check("R12 offset 0", got, 8'h00);
    busRead(4'h7, got); check("R12 offset 7", got, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule